// File: doc/BRIEF.md
# Parallel-Load Serial-Out Shift Register

This block is an eight-stage register. While its active-low load control is asserted, it copies a parallel byte into its stages. While the load is released, it moves its contents one stage toward the output on each rising edge of a shift clock. The last stage is presented twice, as a true serial output and as its complement. Both are meant for driving a serial line or for chaining into further registers.

The shift clock is formed inside the block by OR-ing two clock inputs. Either input can therefore carry its own clock source. Alternatively, one input can be held high to stop the shifting driven by the other, which makes it an active-low clock enable.

The design runs entirely on one fast system clock. The two clock inputs and the load control pass through two-flop synchronizers. A shift happens when the synchronized OR of the two clock inputs changes from 0 to 1. The parallel data lines are sampled directly and must be stable while the load is asserted.

Top module: `piso_shifter`

## Requirements
- R1: When the active-high synchronous reset is applied, every stage is cleared. The true output then reads 0 and the complement output reads 1.
- R2: While the load input is LOW, parallel bit i goes into stage i, and stage 7 drives the true output. A byte that has been loaded therefore leaves the register bit 7 first, then bit 6, and so on, one bit per shift.
- R3: With the load HIGH, each 0-to-1 change of the OR of the two clock inputs moves every stage i into stage i+1. In the same step the serial input enters stage 0.
- R4: The complement output is always the inverse of the true output.
- R5: Either clock input on its own, with the other held LOW, produces one shift per rising edge.
- R6: While one clock input is held HIGH, edges on the other clock input cause no shift.
- R7: While the load stays LOW, the register is reloaded from the parallel lines every system cycle. Clock edges during that time are discarded and are not acted on after the load is released.
- R8: A rising edge of the combined clock that reaches the block together with the release of the load causes no shift. The loaded byte is kept.
- R9: A 1-to-0 change of the combined clock causes no shift.
- R10: With the load HIGH and no clock edge, the register contents stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| loadN | input | 1 | Parallel load control, active low, level sensitive |
| parIn | input | 8 | Parallel data; bit i goes to stage i |
| serIn | input | 1 | Serial data entering stage 0 on a shift |
| clkA | input | 1 | First shift clock input (ORed with clkB) |
| clkB | input | 1 | Second shift clock input (ORed with clkA) |
| serOut | output | 1 | True value of stage 7 |
| serOutN | output | 1 | Complement of stage 7 |

## Verification
Two functions can fall in the same system cycle: the parallel load, and a shift triggered by a rising clock edge. The bench provokes this in two ways. First, it raises a clock input while the load is held LOW. Second, it releases the load and raises a clock input on the same cycle, so that both changes pass through the synchronizers together. In both cases the result is judged by shifting the whole register out through the serial output and comparing it with the byte that was loaded. Any stray shift would show up as a one-place offset and as a serial-input bit appearing in the first position.

// File: rtl/piso_pkg.sv
package piso_pkg;
  // Strobes from control to datapath; at most one is high in any cycle.
  typedef struct packed {
    logic load;
    logic shift;
  } piso_strobe_t;
endpackage

// File: rtl/piso_sync.sv
module piso_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= RESET_VAL;
          else     chain[s] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= RESET_VAL;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/piso_ctrl.sv
module piso_ctrl
  import piso_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         loadNSync,
  input  logic         clkASync,
  input  logic         clkBSync,
  output piso_strobe_t strb
);
  logic combClk;
  logic prevComb;
  logic prevLoadN;
  logic riseSeen;
  logic released;

  assign combClk = clkASync | clkBSync;

  // The edge history advances even during a load, so an edge seen
  // while loading is used up and never shifts later.
  always_ff @(posedge clk) begin
    if (rst) begin
      prevComb  <= 1'b0;
      prevLoadN <= 1'b1;
    end else begin
      prevComb  <= combClk;
      prevLoadN <= loadNSync;
    end
  end

  assign riseSeen = combClk & ~prevComb;
  assign released = loadNSync & ~prevLoadN;

  always_comb begin
    strb.load  = ~loadNSync;
    strb.shift = riseSeen & loadNSync & ~released;
  end
endmodule

// File: rtl/piso_datapath.sv
module piso_datapath
  import piso_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  piso_strobe_t     strb,
  input  logic [WIDTH-1:0] parIn,
  input  logic             serIn,
  output logic [WIDTH-1:0] stages
);
  logic [WIDTH-1:0] shiftNext;

  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_bit
      if (i == 0) begin : g_head
        assign shiftNext[i] = serIn;
      end else begin : g_body
        assign shiftNext[i] = stages[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)             stages <= '0;
    else if (strb.load)  stages <= parIn;
    else if (strb.shift) stages <= shiftNext;
  end
endmodule

// File: rtl/piso_shifter.sv
module piso_shifter
  import piso_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             loadN,
  input  logic [WIDTH-1:0] parIn,
  input  logic             serIn,
  input  logic             clkA,
  input  logic             clkB,
  output logic             serOut,
  output logic             serOutN
);
  localparam int NUM_SYNC = 3;
  localparam logic [NUM_SYNC-1:0] SYNC_RESET = 3'b100;

  logic [NUM_SYNC-1:0] rawCtl;
  logic [NUM_SYNC-1:0] syncCtl;
  logic                loadNSync;
  piso_strobe_t        strb;
  logic [WIDTH-1:0]    stages;

  assign rawCtl    = {loadN, clkB, clkA};
  assign loadNSync = syncCtl[2];

  piso_sync #(
    .WIDTH(NUM_SYNC), .STAGES(SYNC_STAGES), .RESET_VAL(SYNC_RESET)
  ) i_sync (
    .clk(clk), .rst(rst), .asyncIn(rawCtl), .syncOut(syncCtl)
  );

  piso_ctrl i_ctrl (
    .clk(clk), .rst(rst), .loadNSync(loadNSync),
    .clkASync(syncCtl[0]), .clkBSync(syncCtl[1]), .strb(strb)
  );

  piso_datapath #(.WIDTH(WIDTH)) i_dp (
    .clk(clk), .rst(rst), .strb(strb), .parIn(parIn),
    .serIn(serIn), .stages(stages)
  );

  assign serOut  = stages[WIDTH-1];
  assign serOutN = ~stages[WIDTH-1];
endmodule

// File: rtl/piso_shifter_chk.sv
module piso_shifter_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] parIn,
  input logic             serIn,
  input logic             serOut,
  input logic             serOutN,
  input logic             loadStb,
  input logic             shiftStb,
  input logic             loadSyncN,
  input logic [WIDTH-1:0] stages
);
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (stages == '0)); // R1

  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    loadStb |=> (stages == $past(parIn))); // R2

  AST_SHIFT_MOVE: assert property (@(posedge clk) disable iff (rst)
    (shiftStb && !loadStb) |=> (stages == {$past(stages[WIDTH-2:0]), $past(serIn)})); // R3

  AST_COMPLEMENT: assert property (@(posedge clk) disable iff (rst)
    serOutN != serOut); // R4

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
    loadStb |-> !shiftStb); // R7

  AST_RELEASE_NO_SHIFT: assert property (@(posedge clk) disable iff (rst)
    $rose(loadSyncN) |-> !shiftStb); // R8

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!loadStb && !shiftStb) |=> $stable(stages)); // R10
endmodule

bind piso_shifter piso_shifter_chk #(.WIDTH(WIDTH)) i_chk (
  .clk(clk), .rst(rst), .parIn(parIn), .serIn(serIn),
  .serOut(serOut), .serOutN(serOutN),
  .loadStb(strb.load), .shiftStb(strb.shift),
  .loadSyncN(loadNSync), .stages(stages)
);

// File: tb/test_piso_shifter.sv
module test_piso_shifter;
  localparam int W = 8;
  localparam int SETTLE = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic loadN = 1'b1;
  logic [W-1:0] parIn = '0;
  logic serIn = 1'b0;
  logic clkA = 1'b0;
  logic clkB = 1'b0;
  logic serOut, serOutN;

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  logic [W-1:0] model = '0;

  always #5 clk = ~clk;

  piso_shifter i_piso_shifter (
    .clk(clk), .rst(rst), .loadN(loadN), .parIn(parIn), .serIn(serIn),
    .clkA(clkA), .clkB(clkB), .serOut(serOut), .serOutN(serOutN)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic settle();
    repeat (SETTLE) @(negedge clk);
  endtask

  task automatic checkOut(input string req);
    check(serOut === model[W-1], req, int'(serOut), int'(model[W-1]));
    check(serOutN === ~model[W-1], "R4", int'(serOutN), int'(~model[W-1]));
  endtask

  task automatic doLoad(input logic [W-1:0] v);
    loadN = 1'b0; parIn = v; settle();
    loadN = 1'b1; settle();
    model = v;
  endtask

  // One full pulse on the chosen clock input (0 = clkA, 1 = clkB).
  task automatic pulse(input bit which, input logic din);
    serIn = din;
    if (which) clkB = 1'b1; else clkA = 1'b1;
    settle();
    model = {model[W-2:0], din};
    checkOut(which ? "R5" : "R3");
    if (which) clkB = 1'b0; else clkA = 1'b0;
    settle();
    checkOut("R9");
  endtask

  // Shift out the register and compare every bit with the model.
  task automatic drainCheck(input string req, input logic [W-1:0] fill);
    for (int k = 0; k < W; k++) begin
      check(serOut === model[W-1], req, int'(serOut), int'(model[W-1]));
      pulse(k[0], fill[k]);
    end
  endtask

  initial begin
    fork
      begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
          errors++; checks++;
          $display("FAIL watchdog: actual=timeout expected=done");
          $display("Result: errors=%0d of %0d checks", errors, checks);
          $finish;
        end
      end
    join_none
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    model = '0;
    checkOut("R1");

    // R2, R3, R5: every load value, bit order and serial fill checked.
    for (int v = 0; v < 256; v++) begin
      doLoad(v[W-1:0]);
      checkOut("R2");
      drainCheck("R2", ~v[W-1:0]);
      if (v % 16 == 5) drainCheck("R3", v[W-1:0] ^ 8'h5A);
    end

    // R10: no edge, no change
    doLoad(8'hA5);
    repeat (20) @(negedge clk);
    checkOut("R10");
    drainCheck("R10", 8'h00);

    // R6: clkB held high blocks clkA
    doLoad(8'hC3);
    serIn = 1'b1; clkB = 1'b1; settle();
    model = {model[W-2:0], 1'b1};
    checkOut("R5");
    for (int k = 0; k < 4; k++) begin
      clkA = 1'b1; serIn = k[0]; settle();
      clkA = 1'b0; settle();
      checkOut("R6");
    end
    clkB = 1'b0; settle();
    checkOut("R9");
    drainCheck("R6", 8'hFF);

    // R6: clkA held high blocks clkB
    doLoad(8'h3C);
    serIn = 1'b0; clkA = 1'b1; settle();
    model = {model[W-2:0], 1'b0};
    for (int k = 0; k < 4; k++) begin
      clkB = 1'b1; settle(); clkB = 1'b0; settle();
      checkOut("R6");
    end
    clkA = 1'b0; settle();
    drainCheck("R6", 8'h00);

    // R7: held load reloads and discards edges
    loadN = 1'b0; parIn = 8'h11; settle();
    clkA = 1'b1; settle(); clkA = 1'b0; settle();
    parIn = 8'h96; settle();
    clkB = 1'b1; settle();
    loadN = 1'b1; settle();
    clkB = 1'b0; settle();
    model = 8'h96;
    checkOut("R7");
    drainCheck("R7", 8'h0F);

    // R8: edge arriving together with load release
    loadN = 1'b0; parIn = 8'h81; serIn = 1'b0; settle();
    @(negedge clk);
    loadN = 1'b1; clkA = 1'b1; settle();
    model = 8'h81;
    checkOut("R8");
    clkA = 1'b0; settle();
    drainCheck("R8", 8'hF0);

    // R1: reset mid-stream clears the register
    doLoad(8'hFF);
    rst = 1'b1; @(negedge clk); @(negedge clk);
    rst = 1'b0; @(negedge clk);
    model = '0;
    checkOut("R1");
    drainCheck("R1", 8'hAA);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule